// File: doc/BRIEF.md
# External Pin Edge Conditioner

This block turns a raw external interrupt pin into clean events. First the pin passes a multi-flop synchronizer. A stability filter follows, which accepts a new level only after the synchronized signal has held it for a minimum number of clock cycles. The filtered level is then checked for edges. A small control register picks the edge to detect: falling only, rising only, or both. The same register decides whether a detected edge is also sent on as a start pulse for a linked counter.

Each qualifying edge sets a sticky request flag and raises a one-cycle wake-up pulse. When the link is enabled, it also raises a one-cycle start pulse. The surrounding logic clears the flag when it takes the interrupt or when it runs a skip test on the flag. A level-test output reports whether the filtered pin is at the level chosen by the polarity bit.

The single-edge detector works on a polarity-adjusted copy of the pin. Because of that, changing the polarity bit can flip that copy and set the flag with no pin activity. Software is expected to clear the flag after any polarity change.

Top module: `pin_edge_cond`

## Requirements
- R1: After reset the control register reads 0 and the request flag, start pulse and wake pulse are 0. The filtered level starts high, so the level test reads 0.
- R2: A write stores all four control bits and they read back unchanged. Bit 3 (spare) has no effect on detection. Bit 2 is polarity (0 falling/low, 1 rising/high), bit 1 selects dual-edge detection, and bit 0 enables the start pulse.
- R3: A pin pulse that lasts fewer than 4 clock cycles produces no flag, no wake pulse and no change of the level test.
- R4: A pin level held for 4 or more cycles is accepted. When the pin changes just before clock edge k, the flag and wake pulse are first seen after edge k+6.
- R5: With bit 1 = 0 and bit 2 = 0, only falling edges of the filtered level set the flag.
- R6: With bit 1 = 0 and bit 2 = 1, only rising edges set the flag.
- R7: With bit 1 = 1, both edges set the flag, whatever bit 2 holds.
- R8: Every qualifying edge gives exactly one one-cycle wake pulse. The start pulse follows the same timing, but only when bit 0 was 1 in the cycle the edge was detected.
- R9: The flag stays set until a take or skip-read clear. If a new edge arrives in the same cycle as a clear, the flag stays set.
- R10: In single-edge mode, a polarity change that flips the adjusted level from 0 to 1 sets the flag one cycle after the write. This happens for 0→1 while the pin is high, and for 1→0 while the pin is low. The opposite change does not set the flag.
- R11: The level test is 1 exactly when the filtered level equals bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Asynchronous external pin |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control write data |
| ctrl_rdata | output | 4 | Control register contents |
| take_clr | input | 1 | Interrupt taken: clear flag |
| skip_clr | input | 1 | Skip test executed: clear flag |
| req_flag | output | 1 | Sticky request flag |
| timer_start | output | 1 | One-cycle start pulse for the linked counter |
| wake | output | 1 | One-cycle wake-up pulse |
| level_ok | output | 1 | Level-test result |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new edge, which tests the set-over-clear priority. The bench gets there by counting the fixed pipeline depth from a pin change. It asserts the skip clear so that it meets the exact edge at which the flag is set. The pulse-width boundary at 3 and 4 cycles is swept under every control setting. The spurious flag on a polarity change is reached by writing the polarity while the pin sits at a steady level.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;
   typedef struct packed {
      logic spare;
      logic pol;
      logic dual;
      logic link;
   } edge_ctrl_t;

   localparam int unsigned CTRL_W = $bits(edge_ctrl_t);
endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      genvar i;
      for (i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
   parameter int unsigned MIN_HOLD = 4,
   parameter bit          IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic lvl
);
   generate
      if (MIN_HOLD <= 1) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl <= IDLE_LVL;
            else        lvl <= d;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(MIN_HOLD);
         localparam logic [CW-1:0] LAST = CW'(MIN_HOLD - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl <= IDLE_LVL;
               cnt <= '0;
            end else if (d == lvl) begin
               cnt <= '0;
            end else if (cnt == LAST) begin
               lvl <= d;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pin_edge_classify.sv
module pin_edge_classify #(
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic pol,
   input  logic dual,
   output logic hit
);
   logic prev_lvl;
   logic adj_lvl;
   logic prev_adj;
   logic one_side;
   logic any_side;

   // polarity-adjusted level: active edge of pin becomes a 0->1 here
   assign adj_lvl = pol ? lvl : ~lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= IDLE_LVL;
         prev_adj <= ~IDLE_LVL;
      end else begin
         prev_lvl <= lvl;
         prev_adj <= adj_lvl;
      end
   end

   assign one_side = adj_lvl & ~prev_adj;
   assign any_side = lvl ^ prev_lvl;
   assign hit      = dual ? any_side : one_side;
endmodule

// File: rtl/pin_edge_cond.sv
module pin_edge_cond #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_HOLD    = 4,
   parameter bit          IDLE_LVL    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_raw,
   input  logic       ctrl_we,
   input  logic [3:0] ctrl_wdata,
   output logic [3:0] ctrl_rdata,
   input  logic       take_clr,
   input  logic       skip_clr,
   output logic       req_flag,
   output logic       timer_start,
   output logic       wake,
   output logic       level_ok
);
   import pin_edge_pkg::*;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_HOLD < 1) begin : g_bad_hold
         $error("MIN_HOLD must be at least 1");
      end
      if (CTRL_W != 4) begin : g_bad_ctrl
         $error("control word must be 4 bits");
      end
   endgenerate

   edge_ctrl_t ctrl_q;
   logic       pin_s;
   logic       filt_lvl;
   logic       hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= edge_ctrl_t'(ctrl_wdata);
   end
   assign ctrl_rdata = ctrl_q;

   pin_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
   );

   pin_edge_filter #(.MIN_HOLD(MIN_HOLD), .IDLE_LVL(IDLE_LVL)) i_filt (
      .clk(clk), .rst_n(rst_n), .d(pin_s), .lvl(filt_lvl)
   );

   pin_edge_classify #(.IDLE_LVL(IDLE_LVL)) i_cls (
      .clk(clk), .rst_n(rst_n), .lvl(filt_lvl),
      .pol(ctrl_q.pol), .dual(ctrl_q.dual), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_flag    <= 1'b0;
         timer_start <= 1'b0;
         wake        <= 1'b0;
      end else begin
         if (hit)                       req_flag <= 1'b1;
         else if (take_clr || skip_clr) req_flag <= 1'b0;
         timer_start <= hit & ctrl_q.link;
         wake        <= hit;
      end
   end

   assign level_ok = (filt_lvl == ctrl_q.pol);
endmodule

// File: rtl/pin_edge_cond_chk.sv
module pin_edge_cond_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctrl_we,
   input logic [3:0] ctrl_rdata,
   input logic       take_clr,
   input logic       skip_clr,
   input logic       req_flag,
   input logic       timer_start,
   input logic       wake
);
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_we |=> $stable(ctrl_rdata)); // R2

   AST_START_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
      timer_start |-> $past(ctrl_rdata[0])); // R8

   AST_START_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      timer_start |-> wake); // R8

   AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> req_flag); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_flag && !take_clr && !skip_clr) |=> req_flag); // R9

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_flag) |-> wake); // R4
endmodule

bind pin_edge_cond pin_edge_cond_chk i_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_rdata(ctrl_rdata),
   .take_clr(take_clr), .skip_clr(skip_clr), .req_flag(req_flag),
   .timer_start(timer_start), .wake(wake)
);

// File: tb/test_pin_edge_cond.sv
module test_pin_edge_cond;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_raw = 1'b1;
   logic       ctrl_we = 1'b0;
   logic [3:0] ctrl_wdata = 4'h0;
   logic [3:0] ctrl_rdata;
   logic       take_clr = 1'b0;
   logic       skip_clr = 1'b0;
   logic       req_flag, timer_start, wake, level_ok;

   int checks = 0;
   int failures = 0;
   int wake_cnt = 0;
   int ts_cnt = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   pin_edge_cond i_pin_edge_cond (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .take_clr(take_clr), .skip_clr(skip_clr), .req_flag(req_flag),
      .timer_start(timer_start), .wake(wake), .level_ok(level_ok)
   );

   always @(negedge clk) begin
      wake_cnt += int'(wake);
      ts_cnt   += int'(timer_start);
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures + 0);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_ctrl(input logic [3:0] v);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 1'b0;
   endtask

   task automatic skip_pulse();
      @(negedge clk); skip_clr = 1'b1;
      @(negedge clk); skip_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 ctrl", ctrl_rdata, 0);
      check("R1 flag", req_flag, 0);
      check("R1 start", timer_start, 0);
      check("R1 wake", wake, 0);
      check("R1 level_ok", level_ok, 0);

      // R2 write/readback incl spare bit 3
      write_ctrl(4'b1000);
      check("R2 readback spare", ctrl_rdata, 8);
      repeat (3) @(negedge clk);
      check("R2 spare no flag", req_flag, 0);
      write_ctrl(4'b0101);
      check("R2 readback", ctrl_rdata, 5);
      write_ctrl(4'b0000);
      repeat (2) @(negedge clk);
      skip_pulse();

      // R4 exact latency, falling edge, pol=0 single
      wake_cnt = 0;
      @(negedge clk); pin_raw = 1'b0;
      repeat (6) @(negedge clk);
      check("R4 flag not yet", req_flag, 0);
      @(negedge clk);
      check("R4 flag set", req_flag, 1);
      check("R4 wake pulse", wake, 1);
      @(negedge clk);
      check("R4 wake one cycle", wake, 0);
      check("R11 low level match", level_ok, 1);
      // R9 flag sticky, cleared by take
      repeat (5) @(negedge clk);
      check("R9 sticky", req_flag, 1);
      take_clr = 1'b1;
      @(negedge clk); take_clr = 1'b0;
      check("R9 take clear", req_flag, 0);

      // R10 polarity 1->0 while pin low sets flag
      write_ctrl(4'b0100);
      skip_pulse();
      check("R10 cleared", req_flag, 0);
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 4'b0000;
      @(negedge clk); ctrl_we = 1'b0;
      check("R10 not before", req_flag, 0);
      @(negedge clk);
      check("R10 spurious set low", req_flag, 1);
      skip_pulse();

      // back to idle high, then clear
      pin_raw = 1'b1;
      repeat (12) @(negedge clk);
      skip_pulse();
      check("R5 rising ignored", req_flag, 0);

      // R10 polarity 0->1 while pin high sets flag
      @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 4'b0100;
      @(negedge clk); ctrl_we = 1'b0;
      @(negedge clk);
      check("R10 spurious set high", req_flag, 1);
      skip_pulse();
      // opposite change does not set
      write_ctrl(4'b0000);
      repeat (2) @(negedge clk);
      check("R10 opposite no set", req_flag, 0);

      // R9 set wins over simultaneous clear
      @(negedge clk); pin_raw = 1'b0;
      repeat (6) @(negedge clk);
      skip_clr = 1'b1;
      @(negedge clk); skip_clr = 1'b0;
      check("R9 set over clear", req_flag, 1);
      pin_raw = 1'b1;
      repeat (12) @(negedge clk);
      skip_pulse();

      // Sweep: every control setting, pulse widths 1..6
      for (int cfg = 0; cfg < 8; cfg++) begin
         for (int w = 1; w <= 6; w++) begin
            int acc, hits, dual, link, pol;
            link = cfg & 1;
            dual = (cfg >> 1) & 1;
            pol  = (cfg >> 2) & 1;
            acc  = (w >= 4) ? 1 : 0;
            hits = acc ? (dual ? 2 : 1) : 0;
            write_ctrl(4'(cfg) | 4'b1000);
            repeat (2) @(negedge clk);
            skip_pulse();
            @(negedge clk);
            wake_cnt = 0; ts_cnt = 0;
            pin_raw = 1'b0;
            repeat (w) @(negedge clk);
            pin_raw = 1'b1;
            if (!acc) begin
               repeat (3) @(negedge clk);
               check("R3 level unchanged", level_ok, (pol == 1) ? 1 : 0);
               repeat (11) @(negedge clk);
            end else begin
               repeat (14) @(negedge clk);
            end
            if (dual) check("R7 wake count", wake_cnt, hits);
            else if (pol) check("R6 wake count", wake_cnt, hits);
            else check("R5 wake count", wake_cnt, hits);
            check("R8 start count", ts_cnt, link ? hits : 0);
            check("R3 R4 flag", req_flag, hits > 0 ? 1 : 0);
            check("R11 level", level_ok, (pol == 1) ? 1 : 0);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule